// File: doc/BRIEF.md
# Activity-Driven Power Mode Controller

This block walks a system down a ladder of six power modes (full-speed clock, reduced-speed clock, doze, sleep, suspend and off) while the system is idle. It pulls the system back to full speed as soon as monitored bus activity appears. Every step down has its own programmable idle count. A single down-counter is reloaded on each mode entry and on every activity event that is seen. Activity comes from a set of strobes that can be masked one by one, and from I/O accesses whose address lies inside a programmable inclusive window.

A one-cycle suspend/resume pulse forces suspend from any active mode. The same pulse returns the system to full speed from suspend or off. Each mode drives its own software-chosen pattern on five power-control pins. The block also drives clock-select controls and a refresh-keep enable for memory that must retain its contents. Software programs the block through a simple single-cycle register write port. These are control pins, not a data stream, so there is no valid/ready handshake.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the mode becomes full-speed (0), every timeout becomes 0, the low-power refresh bit is cleared, and every mode pattern becomes 5'b01000, so only pin 3 is high.
- R2: Modes are encoded full-speed=0, reduced-speed=1, doze=2, sleep=3, suspend=4, off=5. Register address k (0..4) holds the idle count T of mode k. With T nonzero and no activity, the block leaves mode k for mode k+1 after T cycles, counted from entry or from the last reload.
- R3: A timeout value of 0 disables the step down from that mode. The mode is held indefinitely.
- R4: Activity strobe i counts when bit i of the mask register (address 13) is 1. Counted activity in modes 0 to 3 moves the block to mode 0 at the next edge and reloads the count with the mode 0 timeout.
- R5: A strobe whose mask bit is 0 has no effect on the mode or on the count.
- R6: An I/O strobe whose address is between the base (address 11) and the limit (address 12), both ends included, counts as activity. An address outside that range is ignored.
- R7: A `susres_req` pulse in modes 0 to 3 moves the block to suspend. A pulse in suspend or off moves it to mode 0. The pulse takes priority over activity and over the timer.
- R8: In suspend and off, activity is ignored. The block leaves these modes only by a `susres_req` pulse or by reset.
- R9: `pctl_o` equals the pattern register at address 5+mode, bits [4:0].
- R10: `hs_pll_en` is high only in mode 0. `ls_pll_en` is high in modes 1 to 3. `cpu_clk_en` is high only in modes 0 and 1.
- R11: `refresh_keep` is always high in suspend. In off it is high only when bit 0 of address 14 is set. In all other modes it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_stb | input | 4 | Activity strobes, one per source |
| io_addr | input | 16 | I/O access address |
| io_stb | input | 1 | I/O access strobe |
| susres_req | input | 1 | Suspend/resume request pulse |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| mode_o | output | 3 | Current power mode |
| pctl_o | output | 5 | Power-control pins |
| hs_pll_en | output | 1 | Full-speed clock source select |
| ls_pll_en | output | 1 | Reduced-speed clock source select |
| cpu_clk_en | output | 1 | Processor clock running |
| refresh_keep | output | 1 | Memory refresh retained |

## Verification
A wrong idle count or a wrong mode register shows up on `mode_o` and on `pctl_o` within one cycle of the edge where the mode should have changed, or should have stayed. A missed counter reload shows up as a step down that comes a few cycles early. The bench keeps a behavioural model and compares every output on every cycle, so any such difference is reported in the cycle where it first appears. Directed checks confirm the mask, the window bounds, the suspend priority and the refresh behaviour at their edges.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    M_HS    = 3'd0,
    M_LS    = 3'd1,
    M_DOZE  = 3'd2,
    M_SLEEP = 3'd3,
    M_SUSP  = 3'd4,
    M_OFF   = 3'd5
  } mode_t;

  localparam int N_MODES   = 6;
  localparam int N_STEPS   = 5;
  localparam int A_TMO0    = 0;
  localparam int A_PAT0    = A_TMO0 + N_STEPS;
  localparam int A_IO_BASE = A_PAT0 + N_MODES;
  localparam int A_IO_LIM  = A_IO_BASE + 1;
  localparam int A_MASK    = A_IO_LIM + 1;
  localparam int A_MISC    = A_MASK + 1;
endpackage

// File: rtl/pmc_regs.sv
module pmc_regs
  import pwr_mode_pkg::*;
#(
  parameter int TMR_W  = 16,
  parameter int IO_AW  = 16,
  parameter int N_ACT  = 4,
  parameter int N_PINS = 5,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter logic [N_PINS-1:0] PIN_RST = N_PINS'(8)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  output logic [N_STEPS-1:0][TMR_W-1:0]     tmo,
  output logic [N_MODES-1:0][N_PINS-1:0]    pat,
  output logic [IO_AW-1:0]                  io_base,
  output logic [IO_AW-1:0]                  io_limit,
  output logic [N_ACT-1:0]                  act_mask,
  output logic                              lp_refresh
);
  for (genvar i = 0; i < N_STEPS; i++) begin : g_tmo
    always_ff @(posedge clk) begin
      if (!rst_n)                                          tmo[i] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(A_TMO0 + i))    tmo[i] <= wr_data[TMR_W-1:0];
    end
  end

  for (genvar j = 0; j < N_MODES; j++) begin : g_pat
    always_ff @(posedge clk) begin
      if (!rst_n)                                          pat[j] <= PIN_RST;
      else if (wr_en && wr_addr == ADDR_W'(A_PAT0 + j))    pat[j] <= wr_data[N_PINS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_base    <= '1;
      io_limit   <= '0;
      act_mask   <= '0;
      lp_refresh <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_IO_BASE)) io_base    <= wr_data[IO_AW-1:0];
      if (wr_addr == ADDR_W'(A_IO_LIM))  io_limit   <= wr_data[IO_AW-1:0];
      if (wr_addr == ADDR_W'(A_MASK))    act_mask   <= wr_data[N_ACT-1:0];
      if (wr_addr == ADDR_W'(A_MISC))    lp_refresh <= wr_data[0];
    end
  end
endmodule

// File: rtl/pmc_act_detect.sv
module pmc_act_detect #(
  parameter int N_ACT = 4,
  parameter int IO_AW = 16
) (
  input  logic [N_ACT-1:0] act_stb,
  input  logic [N_ACT-1:0] act_mask,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_stb,
  input  logic [IO_AW-1:0] io_base,
  input  logic [IO_AW-1:0] io_limit,
  output logic             act_hit
);
  logic io_in_window;
  assign io_in_window = io_stb && (io_addr >= io_base) && (io_addr <= io_limit);
  assign act_hit      = (|(act_stb & act_mask)) || io_in_window;
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          act_hit,
  input  logic                          susres_req,
  input  logic [N_STEPS-1:0][TMR_W-1:0] tmo,
  output mode_t                         mode_q
);
  logic [TMR_W-1:0] cnt_q, cnt_d, cur_tmo, nxt_tmo;
  mode_t            mode_d, mode_nxt;
  logic             sleeping;

  assign sleeping = (mode_q == M_SUSP) || (mode_q == M_OFF);
  assign mode_nxt = mode_t'(mode_q + 3'd1);

  always_comb begin
    cur_tmo = '0;
    nxt_tmo = '0;
    for (int k = 0; k < N_STEPS; k++) begin
      if (mode_q == mode_t'(k))   cur_tmo = tmo[k];
      if (mode_nxt == mode_t'(k)) nxt_tmo = tmo[k];
    end
  end

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    if (susres_req) begin
      if (sleeping) begin
        mode_d = M_HS;
        cnt_d  = tmo[0];
      end else begin
        mode_d = M_SUSP;
        cnt_d  = tmo[N_STEPS-1];
      end
    end else if (act_hit && !sleeping) begin
      mode_d = M_HS;
      cnt_d  = tmo[0];
    end else if (mode_q != M_OFF && cur_tmo != '0) begin
      if (cnt_q <= TMR_W'(1)) begin
        mode_d = mode_nxt;
        cnt_d  = nxt_tmo;
      end else begin
        cnt_d  = cnt_q - TMR_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_HS;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int N_ACT  = 4,
  parameter int IO_AW  = 16,
  parameter int TMR_W  = 16,
  parameter int N_PINS = 5,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_ACT-1:0]  act_stb,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_stb,
  input  logic              susres_req,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [2:0]        mode_o,
  output logic [N_PINS-1:0] pctl_o,
  output logic              hs_pll_en,
  output logic              ls_pll_en,
  output logic              cpu_clk_en,
  output logic              refresh_keep
);
  localparam logic [N_PINS-1:0] PIN_RST = N_PINS'(1) << 3;

  logic [N_STEPS-1:0][TMR_W-1:0]  tmo;
  logic [N_MODES-1:0][N_PINS-1:0] pat;
  logic [IO_AW-1:0]               io_base, io_limit;
  logic [N_ACT-1:0]               act_mask;
  logic                           lp_refresh;
  logic                           act_hit;
  mode_t                          mode_q;

  pmc_regs #(
    .TMR_W(TMR_W), .IO_AW(IO_AW), .N_ACT(N_ACT), .N_PINS(N_PINS),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PIN_RST(PIN_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tmo(tmo), .pat(pat), .io_base(io_base), .io_limit(io_limit),
    .act_mask(act_mask), .lp_refresh(lp_refresh)
  );

  pmc_act_detect #(.N_ACT(N_ACT), .IO_AW(IO_AW)) u_act (
    .act_stb(act_stb), .act_mask(act_mask), .io_addr(io_addr), .io_stb(io_stb),
    .io_base(io_base), .io_limit(io_limit), .act_hit(act_hit)
  );

  pmc_mode_fsm #(.TMR_W(TMR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .act_hit(act_hit), .susres_req(susres_req),
    .tmo(tmo), .mode_q(mode_q)
  );

  always_comb begin
    pctl_o = PIN_RST;
    for (int k = 0; k < N_MODES; k++)
      if (mode_q == mode_t'(k)) pctl_o = pat[k];
  end

  assign mode_o       = mode_q;
  assign hs_pll_en    = (mode_q == M_HS);
  assign ls_pll_en    = (mode_q == M_LS) || (mode_q == M_DOZE) || (mode_q == M_SLEEP);
  assign cpu_clk_en   = (mode_q == M_HS) || (mode_q == M_LS);
  assign refresh_keep = (mode_q == M_SUSP) || ((mode_q == M_OFF) && lp_refresh);
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       susres_req,
  input logic       act_hit,
  input logic [2:0] mode_o,
  input logic       hs_pll_en,
  input logic       ls_pll_en,
  input logic       cpu_clk_en,
  input logic       refresh_keep
);
  AST_RESET_TO_HS: assert property (@(posedge clk) !rst_n |=> mode_o == 3'd0); // R1

  AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_o) |-> (mode_o == 3'd0) || (mode_o == 3'd4) ||
                         (mode_o == $past(mode_o) + 3'd1)); // R2

  AST_ACT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_hit && !susres_req && mode_o <= 3'd3) |=> mode_o == 3'd0); // R4

  AST_FORCE_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    (susres_req && mode_o <= 3'd3) |=> mode_o == 3'd4); // R7

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_hit && !susres_req && mode_o == 3'd4) |=> mode_o >= 3'd4); // R8

  AST_PLL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hs_pll_en, ls_pll_en})); // R10

  AST_CPU_CLK_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> mode_o <= 3'd1); // R10

  AST_SUSP_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == 3'd4 |-> refresh_keep); // R11
endmodule

bind pwr_mode_ctrl pmc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .susres_req(susres_req), .act_hit(act_hit),
  .mode_o(mode_o), .hs_pll_en(hs_pll_en), .ls_pll_en(ls_pll_en),
  .cpu_clk_en(cpu_clk_en), .refresh_keep(refresh_keep)
);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  act_stb = '0;
  logic [15:0] io_addr = '0;
  logic        io_stb = 1'b0;
  logic        susres_req = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  mode_o;
  logic [4:0]  pctl_o;
  logic        hs_pll_en, ls_pll_en, cpu_clk_en, refresh_keep;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .act_stb(act_stb), .io_addr(io_addr), .io_stb(io_stb),
    .susres_req(susres_req), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_o(mode_o), .pctl_o(pctl_o), .hs_pll_en(hs_pll_en), .ls_pll_en(ls_pll_en),
    .cpu_clk_en(cpu_clk_en), .refresh_keep(refresh_keep)
  );

  // behavioural reference model
  int m_mode = 0, m_cnt = 0, m_base = 16'hFFFF, m_lim = 0, m_mask = 0, m_lp = 0;
  int m_tmo[5] = '{0, 0, 0, 0, 0};
  int m_pat[6] = '{8, 8, 8, 8, 8, 8};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_base = 16'hFFFF; m_lim = 0; m_mask = 0; m_lp = 0;
      foreach (m_tmo[k]) m_tmo[k] = 0;
      foreach (m_pat[k]) m_pat[k] = 8;
    end else begin
      bit act;
      act = ((int'(act_stb) & m_mask) != 0) ||
            (io_stb && int'(io_addr) >= m_base && int'(io_addr) <= m_lim);
      if (susres_req) begin
        if (m_mode >= 4) begin m_mode = 0; m_cnt = m_tmo[0]; end
        else begin m_mode = 4; m_cnt = m_tmo[4]; end
      end else if (act && m_mode < 4) begin
        m_mode = 0; m_cnt = m_tmo[0];
      end else if (m_mode < 5 && m_tmo[m_mode] != 0) begin
        if (m_cnt <= 1) begin
          m_mode = m_mode + 1;
          m_cnt = (m_mode < 5) ? m_tmo[m_mode] : 0;
        end else m_cnt = m_cnt - 1;
      end
      if (wr_en) begin
        if (wr_addr < 5)        m_tmo[wr_addr] = int'(wr_data);
        else if (wr_addr < 11)  m_pat[wr_addr - 5] = int'(wr_data) & 31;
        else if (wr_addr == 11) m_base = int'(wr_data);
        else if (wr_addr == 12) m_lim = int'(wr_data);
        else if (wr_addr == 13) m_mask = int'(wr_data) & 15;
        else if (wr_addr == 14) m_lp = int'(wr_data) & 1;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, sampled away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R2 mode", int'(mode_o), m_mode);
      chk("R9 pins", int'(pctl_o), m_pat[m_mode]);
      chk("R10 clocks", int'({hs_pll_en, ls_pll_en, cpu_clk_en}),
          ((m_mode == 0) ? 4 : 0) + ((m_mode >= 1 && m_mode <= 3) ? 2 : 0) + ((m_mode <= 1) ? 1 : 0));
      chk("R11 refresh", int'(refresh_keep), (m_mode == 4 || (m_mode == 5 && m_lp == 1)) ? 1 : 0);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe(int bits);
    act_stb = 4'(bits);
    @(negedge clk);
    act_stb = '0;
  endtask

  task automatic io_access(int addr);
    io_stb = 1'b1; io_addr = 16'(addr);
    @(negedge clk);
    io_stb = 1'b0;
  endtask

  task automatic susres();
    susres_req = 1'b1;
    @(negedge clk);
    susres_req = 1'b0;
  endtask

  initial begin
    idle(3);
    chk("R1 reset mode", int'(mode_o), 0);
    chk("R1 reset pins", int'(pctl_o), 8);
    rst_n = 1'b1;
    idle(2);

    for (int k = 0; k < 6; k++) wr(5 + k, 3 * k + 5);
    wr(1, 3); wr(2, 2); wr(3, 2); wr(4, 0); wr(13, 5); wr(0, 4);
    strobe(1);
    idle(30);
    chk("R3 suspend held with zero timeout", int'(mode_o), 4);
    chk("R9 suspend pattern", int'(pctl_o), 17);
    chk("R11 refresh in suspend", int'(refresh_keep), 1);

    strobe(15);
    chk("R8 activity ignored in suspend", int'(mode_o), 4);

    susres();
    chk("R7 resume to full speed", int'(mode_o), 0);
    idle(4);
    chk("R2 demoted after four idle cycles", int'(mode_o), 1);
    chk("R10 reduced clock", int'({hs_pll_en, ls_pll_en, cpu_clk_en}), 3);

    strobe(2);
    chk("R5 masked strobe ignored", int'(mode_o), 1);
    strobe(4);
    chk("R4 unmasked strobe wakes", int'(mode_o), 0);

    wr(11, 16'h0300); wr(12, 16'h030F);
    strobe(1);
    idle(7);
    chk("R2 doze reached", int'(mode_o), 2);
    io_access(16'h0310);
    chk("R6 address above window ignored", int'(mode_o), 2);
    io_access(16'h030F);
    chk("R6 window limit counts as activity", int'(mode_o), 0);

    susres();
    chk("R7 forced suspend", int'(mode_o), 4);
    wr(4, 3);
    idle(1);
    chk("R2 suspend to off", int'(mode_o), 5);
    chk("R11 off without low-power refresh", int'(refresh_keep), 0);
    wr(14, 1);
    chk("R11 off with low-power refresh", int'(refresh_keep), 1);
    chk("R9 off pattern", int'(pctl_o), 20);

    susres();
    chk("R7 resume from off", int'(mode_o), 0);
    wr(0, 0);
    idle(20);
    chk("R3 zero timeout holds full speed", int'(mode_o), 0);

    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    chk("R1 pins after second reset", int'(pctl_o), 8);
    wr(4, 1);
    susres();
    idle(2);
    chk("R2 off after suspend count", int'(mode_o), 5);
    chk("R1 low-power refresh cleared by reset", int'(refresh_keep), 0);
    chk("R1 off pattern after reset", int'(pctl_o), 8);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule